// File: doc/BRIEF.md
# DRAM Address Dehash and Remap Unit

This unit turns a DRAM-format error address into the normalized address that the memory controller uses internally. The incoming 28-bit word carries stack, pseudochannel, row, bank and column fields. The controller may have scrambled the bank and pseudochannel bits with an XOR-parity hash over the column and row bits. The unit removes that scrambling and then packs the fields into a fixed 31-bit permuted layout.

Hash settings live in six configuration registers that are loaded through a simple indexed write port. There is one hash register per bank bit, one for the pseudochannel bit, and one mask that lets bank and stack bits take part in the pseudochannel parity. Requests enter through a valid/ready handshake. Each result is held in a single registered output stage until the consumer takes it.

Top module: `dram_na_remap`

## Requirements
- R1: The input address `in_addr` is split as follows. Column[4:0] is taken from bits 5:1, bank[3:0] from bits 9:6, row[14:0] from bits 24:10, the pseudochannel from bit 25 and stack[1:0] from bits 27:26. Bit 0 is ignored.
- R2: After reset, `out_valid` is 0, `in_ready` is 1 and every hash register is zero. Until a register is written, each request is a plain field remap with no hashing.
- R3: The output `out_addr` is built as follows. Bits 4:0 are 0. Bits 6:5 are column[1:0], bit 7 is the pseudochannel, bits 9:8 are column[3:2], bits 13:12 are bank[1:0] and bits 11:10 are bank[3:2]. Bit 14 is column[4], bits 28:15 are row[13:0] and bits 30:29 are stack[1:0].
- R4: Input row bit 14 never appears in `out_addr`. It still takes part in every hash parity whose row-mask bit 14 is set.
- R5: For each bank bit i whose hash enable is set, bank[i] is inverted when parity(column AND column-mask) XOR parity(row AND row-mask) is 1. Bank bits whose hash enable is clear pass through unchanged.
- R6: When the pseudochannel hash enable is set, the pseudochannel bit is XORed with three parities: column AND its mask, row AND its mask, and the 6-bit bank-xor mask AND a vector {stack[0], 0, dehashed bank[3:0]}. Stack bit 1 therefore never affects the result. The bank bits used here are the values after R5 correction.
- R7: A write with `cfg_we`=1 takes effect for requests accepted after the write cycle. Index 0 to 3 selects bank-bit hash i, index 4 the pseudochannel hash and index 5 the bank-xor mask, taken from `cfg_wdata[5:0]`. In a hash register, bit 0 is the enable, bits 13:1 are the column mask (mask bit k covers column[k]) and bits 31:14 are the row mask (mask bit k covers row[k]). Writes to index 6 or 7 have no effect.
- R8: A request accepted on a clock edge gives `out_valid`=1 right after that edge. With `out_ready`=1, results stream back to back.
- R9: While `out_valid`=1 and `out_ready`=0, the outputs hold stable and `in_ready` is 0.
- R10: `out_bank` reports the four dehashed bank bits and `out_pc` reports the dehashed pseudochannel bit of the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_addr | input | 28 | DRAM-format address |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes result |
| out_addr | output | 31 | Normalized address |
| out_bank | output | 4 | Dehashed bank bits |
| out_pc | output | 1 | Dehashed pseudochannel bit |

## Verification
The bench targets the following corner cases:
- **Row bit 14 (R4).** An input with only row bit 14 set must map to zero. Once that bit is enabled in a row mask, it must flip a bank bit. A design that keeps row bit 14 in the packed output, or leaves it out of the parity, fails one of these two checks.
- **Hash order (R6).** The pseudochannel parity draws on a bank bit that a bank hash just corrected. A design that feeds the raw bank bits would leave the pseudochannel unflipped.
- **Stack bits (R6).** Stack bit 0 must flip the pseudochannel, while stack bit 1 must not. Shifting the stack bits into the vector one place off inverts one of these two checks.
- **Configuration port (R7).** The bench writes to indices 6 and 7 and writes the unused upper bits of the bank-xor register. A loose decoder would corrupt a live mask.
- **Backpressure (R9).** Random backpressure catches a stage that overwrites or drops a held result.

// File: rtl/na_remap_pkg.sv
package na_remap_pkg;
  localparam int COL_W    = 5;
  localparam int BANK_W   = 4;
  localparam int ROW_W    = 15;
  localparam int SID_W    = 2;
  localparam int CMASK_W  = 13;
  localparam int RMASK_W  = 18;
  localparam int BXOR_W   = 6;
  localparam int CFG_W    = 1 + CMASK_W + RMASK_W;
  localparam int IDX_W    = 3;
  localparam int NA_ROW_W = 14;
  localparam int ZERO_W   = 5;
  localparam int IN_W     = 1 + COL_W + BANK_W + ROW_W + 1 + SID_W;
  localparam int OUT_W    = ZERO_W + COL_W + 1 + BANK_W + NA_ROW_W + SID_W;
  localparam int EXT_W    = SID_W + 1 + BANK_W;
  localparam int PC_IDX   = BANK_W;
  localparam int BXOR_IDX = BANK_W + 1;

  typedef struct packed {
    logic               en;
    logic [CMASK_W-1:0] cmask;
    logic [RMASK_W-1:0] rmask;
  } hash_cfg_t;

  typedef struct packed {
    logic [SID_W-1:0]  sid;
    logic              pc;
    logic [ROW_W-1:0]  row;
    logic [BANK_W-1:0] bank;
    logic [COL_W-1:0]  col;
  } dram_fields_t;

  function automatic hash_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
    hash_cfg_t c;
    c.en    = w[0];
    c.cmask = w[CMASK_W:1];
    c.rmask = w[CFG_W-1:CMASK_W+1];
    return c;
  endfunction
endpackage

// File: rtl/hash_cfg_regs.sv
module hash_cfg_regs
  import na_remap_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [IDX_W-1:0]           idx,
  input  logic [CFG_W-1:0]           wdata,
  output hash_cfg_t                  bank_cfg [BANK_W],
  output hash_cfg_t                  pc_cfg,
  output logic [BXOR_W-1:0]          bxor_mask
);
  for (genvar i = 0; i < BANK_W; i++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)                                  bank_cfg[i] <= '0;
      else if (we && idx == IDX_W'(i))          bank_cfg[i] <= unpack_cfg(wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_cfg    <= '0;
      bxor_mask <= '0;
    end else if (we) begin
      if (idx == IDX_W'(PC_IDX))   pc_cfg    <= unpack_cfg(wdata);
      if (idx == IDX_W'(BXOR_IDX)) bxor_mask <= wdata[BXOR_W-1:0];
    end
  end

  // R7: a pseudochannel write lands in the following cycle
  assert_cfg_pc_R7: assert property (@(posedge clk) disable iff (rst)
    we && idx == IDX_W'(PC_IDX) |=> pc_cfg.en == $past(wdata[0]) &&
                                     pc_cfg.rmask == $past(wdata[CFG_W-1:CMASK_W+1]));
  // R7: out-of-range indices leave the mask registers untouched
  assert_cfg_ignore_R7: assert property (@(posedge clk) disable iff (rst)
    we && idx > IDX_W'(BXOR_IDX) |=> $stable(bxor_mask) && $stable(pc_cfg));
endmodule

// File: rtl/dram_dehash.sv
module dram_dehash
  import na_remap_pkg::*;
(
  input  dram_fields_t      f,
  input  hash_cfg_t         bank_cfg [BANK_W],
  input  hash_cfg_t         pc_cfg,
  input  logic [BXOR_W-1:0] bxor_mask,
  output logic [BANK_W-1:0] bank_fix,
  output logic              pc_fix
);
  logic [CMASK_W-1:0] col_ext;
  logic [RMASK_W-1:0] row_ext;
  logic [EXT_W-1:0]   bank_ext;

  assign col_ext = CMASK_W'(f.col);
  assign row_ext = RMASK_W'(f.row);

  for (genvar i = 0; i < BANK_W; i++) begin : g_bit
    logic flip;
    assign flip        = (^(col_ext & bank_cfg[i].cmask)) ^ (^(row_ext & bank_cfg[i].rmask));
    assign bank_fix[i] = f.bank[i] ^ (bank_cfg[i].en & flip);
  end

  // corrected bank bits first, then stack bits two places above them
  assign bank_ext = {f.sid, 1'b0, bank_fix};

  logic pc_flip;
  assign pc_flip = (^(col_ext & pc_cfg.cmask)) ^ (^(row_ext & pc_cfg.rmask)) ^
                   (^(bank_ext & EXT_W'(bxor_mask)));
  assign pc_fix  = f.pc ^ (pc_cfg.en & pc_flip);
endmodule

// File: rtl/na_pack.sv
module na_pack
  import na_remap_pkg::*;
(
  input  dram_fields_t      f,
  input  logic [BANK_W-1:0] bank,
  input  logic              pc,
  output logic [OUT_W-1:0]  na
);
  always_comb begin
    na = {f.sid, f.row[NA_ROW_W-1:0], f.col[4], bank[1:0], bank[3:2],
          f.col[3:2], pc, f.col[1:0], {ZERO_W{1'b0}}};
  end
endmodule

// File: rtl/dram_na_remap.sv
module dram_na_remap
  import na_remap_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_idx,
  input  logic [31:0]          cfg_wdata,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [27:0]          in_addr,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [30:0]          out_addr,
  output logic [3:0]           out_bank,
  output logic                 out_pc
);
  hash_cfg_t         bank_cfg [BANK_W];
  hash_cfg_t         pc_cfg;
  logic [BXOR_W-1:0] bxor_mask;
  dram_fields_t      fields;
  logic [BANK_W-1:0] bank_fix;
  logic              pc_fix;
  logic [OUT_W-1:0]  na;
  logic              accept;

  assign fields = dram_fields_t'(in_addr[IN_W-1:1]);

  hash_cfg_regs u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx), .wdata(cfg_wdata),
    .bank_cfg(bank_cfg), .pc_cfg(pc_cfg), .bxor_mask(bxor_mask)
  );

  dram_dehash u_dehash (
    .f(fields), .bank_cfg(bank_cfg), .pc_cfg(pc_cfg), .bxor_mask(bxor_mask),
    .bank_fix(bank_fix), .pc_fix(pc_fix)
  );

  na_pack u_pack (.f(fields), .bank(bank_fix), .pc(pc_fix), .na(na));

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst)           out_valid <= 1'b0;
    else if (accept)   out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      out_addr <= na;
      out_bank <= bank_fix;
      out_pc   <= pc_fix;
    end
  end

  // R8: an accepted request shows up on the next cycle
  assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);
  // R8: a taken result with nothing new behind it clears the stage
  assert_drain_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !in_valid |=> !out_valid);
  // R9: a stalled result holds
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) &&
                                $stable(out_bank) && $stable(out_pc));
  // R9: no intake while stalled
  assert_stall_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);
endmodule

// File: tb/dram_na_remap_bench.sv
`timescale 1ns/1ps
module dram_na_remap_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [27:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [30:0] out_addr;
  logic [3:0]  out_bank;
  logic        out_pc;

  always #2 clk = ~clk;

  dram_na_remap u_dram_na_remap (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_bank(out_bank), .out_pc(out_pc)
  );

  int checks = 0;
  int fails  = 0;
  int stall_mode = 0;
  bit done = 1'b0;

  logic        m_en [4];
  logic [12:0] m_cm [4];
  logic [17:0] m_rm [4];
  logic        p_en;
  logic [12:0] p_cm;
  logic [17:0] p_rm;
  logic [5:0]  m_bx;

  logic [30:0] q_addr [$];
  logic [3:0]  q_bank [$];
  logic        q_pc   [$];
  string       q_tag  [$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [27:0] a, output logic [30:0] na,
                       output logic [3:0] bk, output logic pc);
    logic [4:0]  col;
    logic [14:0] row;
    logic [1:0]  sid;
    logic [6:0]  ext;
    col = a[5:1]; bk = a[9:6]; row = a[24:10]; pc = a[25]; sid = a[27:26];
    for (int i = 0; i < 4; i++)
      if (m_en[i]) bk[i] = bk[i] ^ (^(col & m_cm[i][4:0])) ^ (^(row & m_rm[i][14:0]));
    if (p_en) begin
      ext = {sid, 1'b0, bk};
      pc = pc ^ (^(col & p_cm[4:0])) ^ (^(row & p_rm[14:0])) ^ (^(ext[5:0] & m_bx));
    end
    na = {sid, row[13:0], col[4], bk[1:0], bk[3:2], col[3:2], pc, col[1:0], 5'b0};
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx < 4) begin
      m_en[idx] = d[0]; m_cm[idx] = d[13:1]; m_rm[idx] = d[31:14];
    end else if (idx == 4) begin
      p_en = d[0]; p_cm = d[13:1]; p_rm = d[31:14];
    end else if (idx == 5) begin
      m_bx = d[5:0];
    end
  endtask

  // driver: pushes the expected result once acceptance is certain
  task automatic send_exp(input logic [27:0] a, input logic [30:0] na, input logic [3:0] bk,
                          input logic pc, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    q_addr.push_back(na); q_bank.push_back(bk); q_pc.push_back(pc); q_tag.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send(input logic [27:0] a, input string tag);
    logic [30:0] na; logic [3:0] bk; logic pc;
    model(a, na, bk, pc);
    send_exp(a, na, bk, pc, tag);
  endtask

  task automatic drain();
    while (q_addr.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // out_ready source
  always @(negedge clk) begin
    if (stall_mode == 0)      out_ready = 1'b1;
    else if (stall_mode == 1) out_ready = 1'b0;
    else                      out_ready = ($urandom % 3) != 0;
  end

  // monitor: scoreboard pop on every transfer
  initial begin
    forever begin
      @(negedge clk); #1;
      if (!rst && out_valid && out_ready) begin
        if (q_addr.size() == 0) begin
          checks++; fails++;
          $display("FAIL R8: unexpected result actual 0x%0h expected none", out_addr);
        end else begin
          string t;
          t = q_tag.pop_front();
          check({t, " addr"}, 32'(out_addr), 32'(q_addr.pop_front()));
          check({t, " R10 bank"}, 32'(out_bank), 32'(q_bank.pop_front()));
          check({t, " R10 pc"}, 32'(out_pc), 32'(q_pc.pop_front()));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [30:0] na1; logic [3:0] bk1; logic pc1;
    for (int i = 0; i < 4; i++) begin m_en[i] = 0; m_cm[i] = 0; m_rm[i] = 0; end
    p_en = 0; p_cm = 0; p_rm = 0; m_bx = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R2 out_valid after reset", 32'(out_valid), 0);
    check("R2 in_ready after reset", 32'(in_ready), 1);

    // R1 R3 pure remap, single fields
    send_exp(28'h0000020, 31'h0000_4000, 4'h0, 1'b0, "R3 col4");
    send_exp(28'h0000002, 31'h0000_0020, 4'h0, 1'b0, "R1 col0");
    send_exp(28'h2000000, 31'h0000_0080, 4'h0, 1'b1, "R3 pc");
    send_exp(28'hC000000, 31'h6000_0000, 4'h0, 1'b0, "R3 sid");
    send_exp(28'h0000040, 31'h0000_1000, 4'h1, 1'b0, "R3 bank0");
    send_exp(28'h0000200, 31'h0000_0800, 4'h8, 1'b0, "R3 bank3");
    send_exp(28'h0000400, 31'h0000_8000, 4'h0, 1'b0, "R3 row0");
    send_exp(28'h1000000, 31'h0000_0000, 4'h0, 1'b0, "R4 row14 dropped");
    send_exp(28'h0000001, 31'h0000_0000, 4'h0, 1'b0, "R1 bit0 ignored");
    send(28'hFFFFFFF, "R2 all ones no hash");
    drain();

    // R4 R5 row14 flips bank2 through its hash
    wr(3'd2, 32'h1000_0001);
    send_exp(28'h1000000, 31'h0000_0400, 4'h4, 1'b0, "R4 row14 in hash");
    // R5 bank0 hash on column0, others disabled pass through
    wr(3'd0, 32'h0000_0003);
    send_exp(28'h0000002, 31'h0000_1020, 4'h1, 1'b0, "R5 bank0 col hash");
    send(28'h00003C2, "R5 mixed");
    drain();

    // R6 pseudochannel hash: stack bit 0 counts, stack bit 1 does not
    wr(3'd4, 32'h0000_0001);
    wr(3'd5, 32'h0000_0020);
    send_exp(28'h4000000, 31'h2000_0080, 4'h0, 1'b1, "R6 sid0 flips pc");
    send_exp(28'h8000000, 31'h4000_0000, 4'h0, 1'b0, "R6 sid1 ignored");
    // R6 uses corrected bank2 (raw bank is 0)
    wr(3'd5, 32'h0000_0004);
    send_exp(28'h1000000, 31'h0000_0480, 4'h4, 1'b1, "R6 dehashed bank feeds pc");
    drain();

    // R7 indices 6 and 7 ignored; upper bank-xor bits ignored
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    send_exp(28'h1000000, 31'h0000_0480, 4'h4, 1'b1, "R7 idx6/7 no effect");
    wr(3'd5, 32'hFFFF_FFC0);
    send_exp(28'h4000000, 31'h2000_0000, 4'h0, 1'b0, "R7 bank-xor low bits only");
    drain();

    // R9 backpressure hold
    stall_mode = 1;
    @(negedge clk);
    model(28'h5A5A5A5, na1, bk1, pc1);
    send(28'h5A5A5A5, "R9 held item");
    in_valid = 1'b1; in_addr = 28'h0123456;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      check("R9 out_valid held", 32'(out_valid), 1);
      check("R9 in_ready low", 32'(in_ready), 0);
      check("R9 out_addr stable", 32'(out_addr), 32'(na1));
    end
    in_valid = 1'b0;
    stall_mode = 0;
    drain();

    // R8 back-to-back and random traffic with random masks and stalls
    for (int r = 0; r < 6; r++) wr(3'(r), $urandom);
    stall_mode = 2;
    for (int n = 0; n < 300; n++) begin
      if (n % 50 == 49) wr(3'($urandom % 6), $urandom);
      send($urandom, "R8 random");
    end
    stall_mode = 0;
    drain();
    check("R8 scoreboard empty", 32'(q_addr.size()), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule